// File: doc/BRIEF.md
# ATA PIO Register Access Engine

This block is the host side of a parallel-ATA register port. A processor hands it one command word per access. The word names a task-file register, the two chip selects, the direction, the 16-bit write data and which of four attached buses to use. The engine then runs the access on the drive pins in three timed phases:

- an address-setup phase;
- a strobe phase, with the read or write strobe asserted;
- a hold phase.

Each phase has its own programmable length in clocks. When the hold phase ends, the engine reports the outcome in a single status word. For a read, that word carries the returned data and a data-available flag. For a write, it carries a write-done flag.

Commands arrive on a valid/ready channel. `cmd_ready` is high only while the engine is enabled and idle, so a held `cmd_valid` simply waits. There is no queue, and a command is taken in the cycle where both are high.

Alongside the access engine sit three small pieces of control:
- a reset-output control bit;
- an enable bit;
- per-bus interrupt capture, with a mask register and a write-one-to-clear acknowledge.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset:
  - `stat_word` is zero, so busy, write-done and data-available are all clear.
  - `cmd_ready` is low, because the enable bit resets to 0.
  - Both strobes, both chip selects and `ata_doe` are low.
  - `ata_rst` is low and `irq_out` is zero.
- R2: `cmd_ready` is high only when the enable bit (`ctl_wdata[0]` written with `ctl_we`) is 1 and the engine is idle. While the enable bit is 0, a held `cmd_valid` starts no access.
- R3: A command is taken at a clock edge where `cmd_valid` and `cmd_ready` are both high. From the next cycle:
  - busy (`stat_word[18]`) stays high for `ls+lt+lh` cycles.
  - During the first `ls` cycles both strobes are low.
  - During the next `lt` cycles exactly one strobe is high.
  - During the last `lh` cycles both strobes are low again.
  - `ls`, `lt` and `lh` are the programmed setup, strobe and hold lengths.
- R4: A programmed length of 0 behaves as a length of 1, so every phase lasts at least one clock.
- R5: The timing register resets to setup 3, strobe 7 and hold 1. A write with `tim_we` loads it in the layout {setup[13:10], strobe[9:4], hold[3:0]}.
- R6: The lengths are captured when a command is taken. A timing write made during an access changes only later accesses.
- R7: The command word fields are:
  - `data` = [15:0]
  - `addr` = [18:16]
  - `cs0` = [19]
  - `cs1` = [20]
  - `rd` = [21]
  - `bus` = [23:22]
  
  While busy, `ata_addr`, `ata_cs0`, `ata_cs1` and `ata_bus` equal these fields. While idle, both chip selects are low.
- R8: A write (`rd`=0) asserts `ata_diow` during the strobe phase and drives `ata_dout` = data with `ata_doe` high for the whole access. When busy falls, write-done (`stat_word[17]`) becomes 1. It clears when the next command is taken.
- R9: A read (`rd`=1):
  - asserts `ata_dior` during the strobe phase and keeps `ata_doe` low;
  - samples `ata_din` in the last strobe cycle;
  - when busy falls, sets data-available (`stat_word[16]`) and places the sample in `stat_word[15:0]`.
  
  Data-available clears on a `stat_rd` pulse or when a new command is taken.
- R10: A rising edge on `irq_in[n]` sets pending bit n. `irq_out[n]` is pending n AND mask bit n, where the mask is written with `mask_we` and resets to 0. An `ack_we` write with bit n set clears pending n. If a rising edge and an acknowledge of the same bus fall in the same cycle, the edge wins. A level held high does not set pending again.
- R11: `ata_rst` follows the reset control bit `ctl_wdata[1]` written with `ctl_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine enabled and idle; command taken when both high |
| cmd_word | input | 24 | Packed command (see R7) |
| stat_rd | input | 1 | Status read strobe; clears data-available |
| stat_word | output | 19 | {busy, write-done, data-available, read data[15:0]} |
| ctl_we | input | 1 | Write strobe for control bits |
| ctl_wdata | input | 2 | {reset output, enable} |
| tim_we | input | 1 | Write strobe for the timing register |
| tim_wdata | input | 14 | {setup, strobe, hold} phase lengths |
| mask_we | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 4 | Interrupt enable per bus |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_wdata | input | 4 | Write one to clear pending interrupt per bus |
| irq_in | input | 4 | Interrupt request from each bus |
| irq_out | output | 4 | Masked pending interrupt per bus |
| ata_bus | output | 2 | Selected bus for the current access |
| ata_addr | output | 3 | Task-file register address |
| ata_cs0 | output | 1 | Chip select 0, active high |
| ata_cs1 | output | 1 | Chip select 1, active high |
| ata_dior | output | 1 | Read strobe, active high |
| ata_diow | output | 1 | Write strobe, active high |
| ata_dout | output | 16 | Write data to the drive |
| ata_doe | output | 1 | Data bus output enable |
| ata_din | input | 16 | Read data from the drive |
| ata_rst | output | 1 | Drive reset, active high |

## Verification
The assertions assume that `irq_in` is synchronous to `clk`. They also assume that mask or acknowledge writes are the only events that can drop an `irq_out` bit. The bench keeps to this by changing `irq_in` only at falling clock edges and by using no other clearing path.

The assertions further assume that `ata_din` is stable while the strobe is high. The bench holds a fixed read value for the whole of each access. It issues commands only through the ready handshake, with random phase lengths from 0 to 5 plus directed default and slow-mode cases.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int NBUS   = 4;
  localparam int BUS_W  = $clog2(NBUS);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // Packed command: bus on top, data at the bottom
  typedef struct packed {
    logic [BUS_W-1:0]  bus;
    logic              rd;
    logic              cs1;
    logic              cs0;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  localparam int CMD_W  = $bits(cmd_t);
  localparam int STAT_W = DATA_W + 3;
endpackage

// File: rtl/ata_cfg_regs.sv
module ata_cfg_regs #(
  parameter int SETUP_W    = 4,
  parameter int STROBE_W   = 6,
  parameter int HOLD_W     = 4,
  parameter int NB         = 4,
  parameter int DEF_SETUP  = 3,
  parameter int DEF_STROBE = 7,
  parameter int DEF_HOLD   = 1,
  localparam int TIM_W     = SETUP_W + STROBE_W + HOLD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [1:0]          ctl_wdata,
  input  logic                tim_we,
  input  logic [TIM_W-1:0]    tim_wdata,
  input  logic                mask_we,
  input  logic [NB-1:0]       mask_wdata,
  output logic                en,
  output logic                drv_rst,
  output logic [SETUP_W-1:0]  setup_q,
  output logic [STROBE_W-1:0] strobe_q,
  output logic [HOLD_W-1:0]   hold_q,
  output logic [NB-1:0]       mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      drv_rst  <= 1'b0;
      setup_q  <= SETUP_W'(DEF_SETUP);
      strobe_q <= STROBE_W'(DEF_STROBE);
      hold_q   <= HOLD_W'(DEF_HOLD);
      mask_q   <= '0;
    end else begin
      if (ctl_we) begin
        en      <= ctl_wdata[0];
        drv_rst <= ctl_wdata[1];
      end
      if (tim_we) begin
        {setup_q, strobe_q, hold_q} <= tim_wdata;
      end
      if (mask_we) begin
        mask_q <= mask_wdata;
      end
    end
  end
endmodule

// File: rtl/ata_phase_timer.sv
module ata_phase_timer
  import ata_pio_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] setup_len,
  input  logic [CW-1:0] strobe_len,
  input  logic [CW-1:0] hold_len,
  output phase_e        phase,
  output logic          strobe_end,
  output logic          hold_end
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] stb_q;
  logic [CW-1:0] hld_q;

  // A length of zero still gives a single clock
  function automatic logic [CW-1:0] final_tick(input logic [CW-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign strobe_end = (phase == PH_STROBE) && (cnt == '0);
  assign hold_end   = (phase == PH_HOLD) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      stb_q <= '0;
      hld_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_SETUP;
            cnt   <= final_tick(setup_len);
            stb_q <= strobe_len;
            hld_q <= hold_len;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= final_tick(stb_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            cnt   <= final_tick(hld_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] irq_in,
  input  logic          ack_we,
  input  logic [NB-1:0] ack_wdata,
  input  logic [NB-1:0] mask_q,
  output logic [NB-1:0] irq_out
);
  logic [NB-1:0] irq_d;
  logic [NB-1:0] pend;

  for (genvar n = 0; n < NB; n++) begin : g_bus
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_d[n] <= 1'b0;
        pend[n]  <= 1'b0;
      end else begin
        irq_d[n] <= irq_in[n];
        if (irq_in[n] && !irq_d[n]) begin
          pend[n] <= 1'b1;          // a new edge outranks an acknowledge
        end else if (ack_we && ack_wdata[n]) begin
          pend[n] <= 1'b0;
        end
      end
    end
    assign irq_out[n] = pend[n] & mask_q[n];
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int SETUP_W    = 4,
  parameter int STROBE_W   = 6,
  parameter int HOLD_W     = 4,
  parameter int DEF_SETUP  = 3,
  parameter int DEF_STROBE = 7,
  parameter int DEF_HOLD   = 1,
  localparam int TIM_W     = SETUP_W + STROBE_W + HOLD_W,
  localparam int CW1       = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W,
  localparam int CW        = (CW1 > STROBE_W) ? CW1 : STROBE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_word,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  input  logic              tim_we,
  input  logic [TIM_W-1:0]  tim_wdata,
  input  logic              mask_we,
  input  logic [NBUS-1:0]   mask_wdata,
  input  logic              ack_we,
  input  logic [NBUS-1:0]   ack_wdata,
  input  logic [NBUS-1:0]   irq_in,
  output logic [NBUS-1:0]   irq_out,
  output logic [BUS_W-1:0]  ata_bus,
  output logic [ADDR_W-1:0] ata_addr,
  output logic              ata_cs0,
  output logic              ata_cs1,
  output logic              ata_dior,
  output logic              ata_diow,
  output logic [DATA_W-1:0] ata_dout,
  output logic              ata_doe,
  input  logic [DATA_W-1:0] ata_din,
  output logic              ata_rst
);
  logic                en;
  logic [SETUP_W-1:0]  setup_q;
  logic [STROBE_W-1:0] strobe_q;
  logic [HOLD_W-1:0]   hold_q;
  logic [NBUS-1:0]     mask_q;

  ata_cfg_regs #(
    .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W), .NB(NBUS),
    .DEF_SETUP(DEF_SETUP), .DEF_STROBE(DEF_STROBE), .DEF_HOLD(DEF_HOLD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tim_we(tim_we), .tim_wdata(tim_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .en(en), .drv_rst(ata_rst),
    .setup_q(setup_q), .strobe_q(strobe_q), .hold_q(hold_q), .mask_q(mask_q)
  );

  ata_irq_ctrl #(.NB(NBUS)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .ack_we(ack_we), .ack_wdata(ack_wdata),
    .mask_q(mask_q), .irq_out(irq_out)
  );

  phase_e phase;
  logic   strobe_end;
  logic   hold_end;
  logic   busy;
  logic   take;

  assign busy      = (phase != PH_IDLE);
  assign cmd_ready = en && !busy;
  assign take      = cmd_valid && cmd_ready;

  ata_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(take),
    .setup_len(CW'(setup_q)), .strobe_len(CW'(strobe_q)), .hold_len(CW'(hold_q)),
    .phase(phase), .strobe_end(strobe_end), .hold_end(hold_end)
  );

  cmd_t              cmd_q;
  logic [DATA_W-1:0] rd_q;
  logic              dav_q;
  logic              wdone_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      rd_q    <= '0;
      dav_q   <= 1'b0;
      wdone_q <= 1'b0;
    end else begin
      if (take) begin
        cmd_q   <= cmd_t'(cmd_word);
        dav_q   <= 1'b0;
        wdone_q <= 1'b0;
      end else if (hold_end) begin
        dav_q   <= cmd_q.rd;
        wdone_q <= !cmd_q.rd;
      end else if (stat_rd) begin
        dav_q   <= 1'b0;
      end
      if (strobe_end && cmd_q.rd) begin
        rd_q <= ata_din;
      end
    end
  end

  assign stat_word = {busy, wdone_q, dav_q, rd_q};

  assign ata_bus  = cmd_q.bus;
  assign ata_addr = busy ? cmd_q.addr : '0;
  assign ata_cs0  = busy && cmd_q.cs0;
  assign ata_cs1  = busy && cmd_q.cs1;
  assign ata_dior = (phase == PH_STROBE) && cmd_q.rd;
  assign ata_diow = (phase == PH_STROBE) && !cmd_q.rd;
  assign ata_dout = cmd_q.data;
  assign ata_doe  = busy && !cmd_q.rd;
endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk
  import ata_pio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              stat_rd,
  input logic [STAT_W-1:0] stat_word,
  input logic              mask_we,
  input logic              ack_we,
  input logic [NBUS-1:0]   irq_out,
  input logic              ata_cs0,
  input logic              ata_cs1,
  input logic              ata_dior,
  input logic              ata_diow,
  input logic              ata_doe
);
  logic bsy;
  logic wdone;
  logic dav;
  assign bsy   = stat_word[STAT_W-1];
  assign wdone = stat_word[STAT_W-2];
  assign dav   = stat_word[STAT_W-3];

  // R3
  busy_from_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy) |-> $past(cmd_valid && cmd_ready));

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_dior || ata_diow) |-> (bsy && !(ata_dior && ata_diow)));

  // R7
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy |-> (!ata_cs0 && !ata_cs1 && !ata_doe));

  // R8
  wdone_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdone) |-> $past(bsy));

  // R9
  dav_cleared_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !bsy) |=> !dav);

  // R10
  irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|irq_out) |-> $past(ack_we || mask_we));
endmodule

bind ata_pio_engine ata_pio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .stat_rd(stat_rd), .stat_word(stat_word), .mask_we(mask_we), .ack_we(ack_we),
  .irq_out(irq_out), .ata_cs0(ata_cs0), .ata_cs1(ata_cs1),
  .ata_dior(ata_dior), .ata_diow(ata_diow), .ata_doe(ata_doe)
);

// File: tb/sim_ata_pio_engine.sv
module sim_ata_pio_engine;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [23:0] cmd_word = '0;
  logic        stat_rd = 1'b0;
  logic [18:0] stat_word;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_wdata = '0;
  logic        tim_we = 1'b0;
  logic [13:0] tim_wdata = '0;
  logic        mask_we = 1'b0;
  logic [3:0]  mask_wdata = '0;
  logic        ack_we = 1'b0;
  logic [3:0]  ack_wdata = '0;
  logic [3:0]  irq_in = '0;
  logic [3:0]  irq_out;
  logic [1:0]  ata_bus;
  logic [2:0]  ata_addr;
  logic        ata_cs0, ata_cs1, ata_dior, ata_diow, ata_doe, ata_rst;
  logic [15:0] ata_dout;
  logic [15:0] ata_din = '0;

  ata_pio_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .stat_rd(stat_rd), .stat_word(stat_word),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tim_we(tim_we), .tim_wdata(tim_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ack_we(ack_we), .ack_wdata(ack_wdata),
    .irq_in(irq_in), .irq_out(irq_out), .ata_bus(ata_bus), .ata_addr(ata_addr),
    .ata_cs0(ata_cs0), .ata_cs1(ata_cs1), .ata_dior(ata_dior), .ata_diow(ata_diow),
    .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din), .ata_rst(ata_rst)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int plen(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] pack(input logic [1:0] bus, input logic rd,
      input logic cs1, input logic cs0, input logic [2:0] a, input logic [15:0] d);
    return {bus, rd, cs1, cs0, a, d};
  endfunction

  task automatic set_timing(input int s, input int t, input int h);
    tim_wdata = {4'(s), 6'(t), 4'(h)};
    tim_we = 1'b1;
    @(negedge clk);
    tim_we = 1'b0;
  endtask

  // One access: expects phase lengths of the captured s,t,h; optionally
  // rewrites the timing register in the first busy cycle.
  task automatic access(input logic rd, input logic [2:0] a, input logic cs0,
      input logic cs1, input logic [1:0] bus, input logic [15:0] d,
      input logic [15:0] dv, input int s, input int t, input int h,
      input bit chg, input int ns, input int nt, input int nh);
    int su = 0, st = 0, ho = 0, guard = 0;
    bit seen = 0, dir_ok = 1, pins_ok = 1;
    ata_din   = dv;
    cmd_word  = pack(bus, rd, cs1, cs0, a, d);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (stat_word[18] && guard < 500) begin
      if (guard == 0 && chg) begin
        tim_wdata = {4'(ns), 6'(nt), 4'(nh)};
        tim_we = 1'b1;
      end else begin
        tim_we = 1'b0;
      end
      if (ata_dior || ata_diow) begin
        st++; seen = 1;
        if (ata_dior != rd || ata_diow != !rd) dir_ok = 0;
      end else if (!seen) su++;
      else ho++;
      if (ata_addr != a || ata_cs0 != cs0 || ata_cs1 != cs1 || ata_bus != bus
          || ata_doe != !rd || (!rd && ata_dout != d)) pins_ok = 0;
      if (guard == 0) begin
        chk(stat_word[16] == 1'b0 && stat_word[17] == 1'b0, "R9",
            "flags cleared on accept", stat_word[17:16], 0);
      end
      guard++;
      @(negedge clk);
    end
    tim_we = 1'b0;
    chk(su == plen(s), "R3", "setup cycles", su, plen(s));
    chk(st == plen(t), "R3", "strobe cycles", st, plen(t));
    chk(ho == plen(h), "R3", "hold cycles", ho, plen(h));
    chk(dir_ok, rd ? "R9" : "R8", "strobe direction", dir_ok, 1);
    chk(pins_ok, "R7", "address/select/data pins", pins_ok, 1);
    if (rd) begin
      chk(stat_word[16] && stat_word[15:0] == dv, "R9", "read data",
          stat_word[16:0], {1'b1, dv});
    end else begin
      chk(stat_word[17] && !stat_word[16], "R8", "write done",
          stat_word[17:16], 2'b10);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(stat_word == '0 && !cmd_ready && irq_out == 0 && !ata_rst, "R1",
        "reset state", {cmd_ready, irq_out, ata_rst, stat_word}, 0);
    chk(!ata_dior && !ata_diow && !ata_cs0 && !ata_cs1 && !ata_doe, "R1",
        "reset pins", {ata_dior, ata_diow, ata_cs0, ata_cs1, ata_doe}, 0);

    // R2: disabled engine ignores a held command
    cmd_word = pack(2'd1, 1'b0, 1'b0, 1'b1, 3'd2, 16'h1234);
    cmd_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cmd_ready && !stat_word[18] && !ata_diow, "R2", "disabled no access",
        {cmd_ready, stat_word[18]}, 0);
    cmd_valid = 1'b0;

    // R11: reset output follows control bit
    ctl_wdata = 2'b10; ctl_we = 1'b1; @(negedge clk); ctl_we = 1'b0;
    chk(ata_rst == 1'b1 && !cmd_ready, "R11", "reset output on", ata_rst, 1);
    ctl_wdata = 2'b01; ctl_we = 1'b1; @(negedge clk); ctl_we = 1'b0;
    chk(ata_rst == 1'b0 && cmd_ready, "R11", "reset off, enabled",
        {ata_rst, cmd_ready}, 1);

    // R5: default timing 3/7/1
    access(1'b0, 3'd7, 1'b1, 1'b0, 2'd0, 16'hBEEF, 16'h0, 3, 7, 1, 0, 0, 0, 0);
    // device control register style access
    access(1'b1, 3'd6, 1'b0, 1'b1, 2'd3, 16'h0, 16'hA55A, 3, 7, 1, 0, 0, 0, 0);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    chk(!stat_word[16], "R9", "dav cleared by status read", stat_word[16], 0);

    // R4: zero lengths give one clock each
    set_timing(0, 0, 0);
    access(1'b1, 3'd1, 1'b1, 1'b0, 2'd2, 16'h0, 16'h0F0F, 0, 0, 0, 0, 0, 0, 0);
    // slowest mode
    set_timing(9, 39, 9);
    access(1'b0, 3'd0, 1'b1, 1'b0, 2'd1, 16'hC3C3, 16'h0, 9, 39, 9, 0, 0, 0, 0);

    // R6: change timing mid-access
    set_timing(2, 3, 2);
    access(1'b0, 3'd4, 1'b1, 1'b0, 2'd0, 16'h5555, 16'h0, 2, 3, 2, 1, 1, 2, 4);
    access(1'b1, 3'd4, 1'b1, 1'b0, 2'd0, 16'h0, 16'h6789, 1, 2, 4, 0, 0, 0, 0);

    // random accesses
    for (int i = 0; i < 30; i++) begin
      int s = $urandom_range(0, 5);
      int t = $urandom_range(0, 5);
      int h = $urandom_range(0, 5);
      logic rd = 1'($urandom_range(0, 1));
      set_timing(s, t, h);
      access(rd, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             16'($urandom), 16'($urandom), s, t, h, 0, 0, 0, 0);
    end

    // R10: interrupts
    mask_wdata = 4'b0101; mask_we = 1'b1; @(negedge clk); mask_we = 1'b0;
    irq_in = 4'b0001; @(negedge clk); irq_in = 4'b0000; @(negedge clk);
    chk(irq_out == 4'b0001, "R10", "edge sets bus 0", irq_out, 4'b0001);
    irq_in = 4'b0010; @(negedge clk); irq_in = 4'b0000; @(negedge clk);
    chk(irq_out == 4'b0001, "R10", "masked bus 1", irq_out, 4'b0001);
    mask_wdata = 4'b1111; mask_we = 1'b1; @(negedge clk); mask_we = 1'b0;
    chk(irq_out == 4'b0011, "R10", "unmask shows pending", irq_out, 4'b0011);
    ack_wdata = 4'b0001; ack_we = 1'b1; @(negedge clk); ack_we = 1'b0;
    chk(irq_out == 4'b0010, "R10", "ack clears bus 0", irq_out, 4'b0010);
    irq_in = 4'b0100; ack_wdata = 4'b0100; ack_we = 1'b1;
    @(negedge clk); ack_we = 1'b0;
    chk(irq_out == 4'b0110, "R10", "edge beats ack", irq_out, 4'b0110);
    irq_in = 4'b1100; @(negedge clk);
    chk(irq_out == 4'b1110, "R10", "bus 3 edge", irq_out, 4'b1110);
    ack_wdata = 4'b1100; ack_we = 1'b1; @(negedge clk); ack_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq_out == 4'b0010, "R10", "held level no re-set", irq_out, 4'b0010);
    irq_in = 4'b0000;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule